// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block turns an addressing-form byte, together with the displacement bytes that may follow it, into an operand location. It takes bytes one at a time over a valid/ready handshake. It accepts exactly as many bytes as the addressing form calls for. When the last byte is in, it reports the three fields of the form byte and one of three results: a 32-bit memory effective address, a register-direct indication, or an error for the scaled-index escape code, which this block does not support.

The base register value comes from an external eight-entry register file read port. The block drives the read index from the rm field and samples the returned value in the cycle before it completes. Results stay on the outputs until the next completion. A one-cycle `done_o` strobe marks each new result. Operand reads and writes happen outside this block.

Top module: `modrm_ea_gen`

## Requirements
- R1: The form byte is split into a mode field (bits 7:6), a reg/sub-operation field (bits 5:3) and an rm field (bits 2:0). The three fields are reported on `mod_o`, `reg_o` and `rm_o` at completion.
- R2: Mode 00 with rm other than 100 and 101 gives the register selected by rm as the address, with no displacement bytes. The read index on `rf_addr_o` equals rm, with register 0 first and the usual 32-bit register order (0 accumulator, 3 base register).
- R3: Mode 00 with rm 101 takes the next four bytes, least significant first, as an absolute address. No register value is added.
- R4: Mode 01 takes one displacement byte, sign-extends it and adds it to the base register. For example, base 0x61 with byte 0xFF gives 0x60.
- R5: Mode 10 takes four displacement bytes, least significant first, and adds them to the base register modulo 2^32. For example, base 0x61 with FF FF FF FF gives 0x60.
- R6: Mode 11 sets `reg_direct_o`, reports an address of zero and takes no displacement bytes.
- R7: rm 100 in modes 00, 01 or 10 sets `sib_err_o`, clears `reg_direct_o`, reports an address of zero and takes no further bytes. The two flags are never both set.
- R8: `done_o` is high for exactly one cycle per form byte. It goes high on the second clock edge after the last byte of the sequence is accepted, and never before that byte is accepted.
- R9: The block accepts exactly 1 plus the displacement length in bytes. `in_ready_o` is low only in the single cycle between the last accepted byte and completion. All result outputs hold their values until the next completion.
- R10: After reset, `done_o`, `reg_direct_o` and `sib_err_o` are low, `ea_o` is zero and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | 8 | Byte stream data |
| in_ready_o | output | 1 | Block can accept a byte |
| rf_addr_o | output | 3 | Register file read index (rm field) |
| rf_data_i | input | ADDR_W | Register file read data |
| done_o | output | 1 | One-cycle completion strobe |
| mod_o | output | 2 | Mode field of the last form byte |
| reg_o | output | 3 | Reg/sub-operation field |
| rm_o | output | 3 | rm field |
| reg_direct_o | output | 1 | Operand is a register, not memory |
| sib_err_o | output | 1 | Unsupported scaled-index form |
| ea_o | output | ADDR_W | Effective address |

## Verification
The assertions check the following properties on every cycle:
- the single-cycle shape of the completion strobe;
- output stability between completions;
- readiness once a result is posted;
- consistency of the two flags with the reported mode and rm fields, and the zero address that goes with them;
- the match between the register read index and rm.

Other behaviours can only be shown by the bench's scenarios, which sweep every form byte over two register sets and check against arithmetic done in the bench:
- the actual address arithmetic (sign extension of the short displacement, wrap of the long one, and the absolute form that ignores the base);
- the exact number of bytes consumed per form;
- the edge on which completion arrives.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

    localparam int FORM_W = 8;
    localparam int RM_W   = 3;

    typedef enum logic [1:0] {
        MD_INDIRECT = 2'b00,
        MD_DISP8    = 2'b01,
        MD_DISP32   = 2'b10,
        MD_DIRECT   = 2'b11
    } mod_e;

    localparam logic [RM_W-1:0] RM_ESCAPE   = 3'b100;
    localparam logic [RM_W-1:0] RM_ABSOLUTE = 3'b101;

    typedef struct packed {
        mod_e            mode;
        logic [2:0]      reg_f;
        logic [RM_W-1:0] rm;
    } modrm_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISP,
        ST_FINISH
    } ctl_st_e;

    function automatic modrm_t split_form(input logic [FORM_W-1:0] b);
        modrm_t f;
        f.mode  = mod_e'(b[7:6]);
        f.reg_f = b[5:3];
        f.rm    = b[2:0];
        return f;
    endfunction

    function automatic logic is_escape(input modrm_t f);
        return (f.mode != MD_DIRECT) && (f.rm == RM_ESCAPE);
    endfunction

    function automatic logic is_absolute(input modrm_t f);
        return (f.mode == MD_INDIRECT) && (f.rm == RM_ABSOLUTE);
    endfunction

endpackage

// File: rtl/modrm_field_dec.sv
module modrm_field_dec
    import modrm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [FORM_W-1:0]                   form_i,
    output modrm_t                              fields_o,
    output logic [$clog2(ADDR_W/8+1)-1:0]       len_o,
    output logic                                use_base_o,
    output logic                                direct_o,
    output logic                                sib_o
);
    localparam int NB    = ADDR_W / 8;
    localparam int CNT_W = $clog2(NB + 1);

    modrm_t f;
    logic   esc;
    logic   absl;

    always_comb begin
        f          = split_form(form_i);
        esc        = is_escape(f);
        absl       = is_absolute(f);
        direct_o   = (f.mode == MD_DIRECT);
        sib_o      = esc;
        use_base_o = !direct_o && !esc && !absl;
        fields_o   = f;
        unique case (f.mode)
            MD_INDIRECT: len_o = absl ? CNT_W'(NB) : '0;
            MD_DISP8:    len_o = esc ? '0 : CNT_W'(1);
            MD_DISP32:   len_o = esc ? '0 : CNT_W'(NB);
            default:     len_o = '0;
        endcase
    end

endmodule

// File: rtl/modrm_disp_shift.sv
module modrm_disp_shift #(
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clear_i,
    input  logic                              shift_i,
    input  logic [7:0]                        byte_i,
    input  logic [$clog2(ADDR_W/8+1)-1:0]     len_i,
    output logic [ADDR_W-1:0]                 disp_o
);
    localparam int NB = ADDR_W / 8;

    logic [7:0]        lane_q [NB];
    logic [ADDR_W-1:0] packed_w;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        if (g == NB - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst || clear_i)
                    lane_q[g] <= '0;
                else if (shift_i)
                    lane_q[g] <= byte_i;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst || clear_i)
                    lane_q[g] <= '0;
                else if (shift_i)
                    lane_q[g] <= lane_q[g+1];
            end
        end
        assign packed_w[g*8 +: 8] = lane_q[g];
    end

    // Bytes enter at the top lane, so a short displacement sits in the top
    // bits; an arithmetic right shift both aligns and sign-extends it.
    always_comb begin
        if (len_i == '0)
            disp_o = '0;
        else
            disp_o = $signed(packed_w) >>> ((NB - int'(len_i)) * 8);
    end

endmodule

// File: rtl/modrm_ea_add.sv
module modrm_ea_add #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic              use_base_i,
    input  logic              zero_i,
    output logic [ADDR_W-1:0] ea_o
);
    logic [ADDR_W-1:0] base_gated;

    always_comb begin
        base_gated = use_base_i ? base_i : '0;
        ea_o       = zero_i ? '0 : (base_gated + disp_i);
    end

endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
    import modrm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    output logic              in_ready_o,
    output logic [2:0]        rf_addr_o,
    input  logic [ADDR_W-1:0] rf_data_i,
    output logic              done_o,
    output logic [1:0]        mod_o,
    output logic [2:0]        reg_o,
    output logic [2:0]        rm_o,
    output logic              reg_direct_o,
    output logic              sib_err_o,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int NB    = ADDR_W / 8;
    localparam int CNT_W = $clog2(NB + 1);

    ctl_st_e           state_q;
    modrm_t            fields_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  rem_q;
    logic              use_base_q;
    logic              direct_q;
    logic              sib_q;

    logic              done_q;
    logic [1:0]        res_mod_q;
    logic [2:0]        res_reg_q;
    logic [2:0]        res_rm_q;
    logic              res_direct_q;
    logic              res_sib_q;
    logic [ADDR_W-1:0] res_ea_q;

    modrm_t            dec_fields;
    logic [CNT_W-1:0]  dec_len;
    logic              dec_use_base;
    logic              dec_direct;
    logic              dec_sib;
    logic [ADDR_W-1:0] disp_w;
    logic [ADDR_W-1:0] ea_next;
    logic              take;

    assign in_ready_o = (state_q != ST_FINISH);
    assign take       = in_valid_i && in_ready_o;
    assign rf_addr_o  = fields_q.rm;

    modrm_field_dec #(.ADDR_W(ADDR_W)) i_dec (
        .form_i     (in_data_i),
        .fields_o   (dec_fields),
        .len_o      (dec_len),
        .use_base_o (dec_use_base),
        .direct_o   (dec_direct),
        .sib_o      (dec_sib)
    );

    modrm_disp_shift #(.ADDR_W(ADDR_W)) i_disp (
        .clk     (clk),
        .rst     (rst),
        .clear_i (take && (state_q == ST_IDLE)),
        .shift_i (take && (state_q == ST_DISP)),
        .byte_i  (in_data_i),
        .len_i   (len_q),
        .disp_o  (disp_w)
    );

    modrm_ea_add #(.ADDR_W(ADDR_W)) i_add (
        .base_i     (rf_data_i),
        .disp_i     (disp_w),
        .use_base_i (use_base_q),
        .zero_i     (direct_q || sib_q),
        .ea_o       (ea_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            fields_q     <= '0;
            len_q        <= '0;
            rem_q        <= '0;
            use_base_q   <= 1'b0;
            direct_q     <= 1'b0;
            sib_q        <= 1'b0;
            done_q       <= 1'b0;
            res_mod_q    <= '0;
            res_reg_q    <= '0;
            res_rm_q     <= '0;
            res_direct_q <= 1'b0;
            res_sib_q    <= 1'b0;
            res_ea_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        fields_q   <= dec_fields;
                        len_q      <= dec_len;
                        rem_q      <= dec_len;
                        use_base_q <= dec_use_base;
                        direct_q   <= dec_direct;
                        sib_q      <= dec_sib;
                        state_q    <= (dec_len == '0) ? ST_FINISH : ST_DISP;
                    end
                end
                ST_DISP: begin
                    if (take) begin
                        rem_q <= rem_q - CNT_W'(1);
                        if (rem_q == CNT_W'(1))
                            state_q <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    done_q       <= 1'b1;
                    res_mod_q    <= fields_q.mode;
                    res_reg_q    <= fields_q.reg_f;
                    res_rm_q     <= fields_q.rm;
                    res_direct_q <= direct_q;
                    res_sib_q    <= sib_q;
                    res_ea_q     <= ea_next;
                    state_q      <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o       = done_q;
    assign mod_o        = res_mod_q;
    assign reg_o        = res_reg_q;
    assign rm_o         = res_rm_q;
    assign reg_direct_o = res_direct_q;
    assign sib_err_o    = res_sib_q;
    assign ea_o         = res_ea_q;

endmodule

// File: rtl/modrm_ea_gen_chk.sv
module modrm_ea_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready_o,
    input logic [2:0]        rf_addr_o,
    input logic              done_o,
    input logic [1:0]        mod_o,
    input logic [2:0]        rm_o,
    input logic              reg_direct_o,
    input logic              sib_err_o,
    input logic [ADDR_W-1:0] ea_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> in_ready_o); // R9

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done_o || $stable(ea_o))); // R9

    AST_DIRECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_o && reg_direct_o) |-> (ea_o == '0 && mod_o == 2'b11)); // R6

    AST_SIB_FLAG: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (sib_err_o == (mod_o != 2'b11 && rm_o == 3'b100))); // R7

    AST_SIB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_o && sib_err_o) |-> (ea_o == '0 && !reg_direct_o)); // R7

    AST_RF_INDEX: assert property (@(posedge clk) disable iff (rst)
        (done_o && !reg_direct_o) |-> (rf_addr_o == rm_o)); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !done_o); // R10

endmodule

bind modrm_ea_gen modrm_ea_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready_o   (in_ready_o),
    .rf_addr_o    (rf_addr_o),
    .done_o       (done_o),
    .mod_o        (mod_o),
    .rm_o         (rm_o),
    .reg_direct_o (reg_direct_o),
    .sib_err_o    (sib_err_o),
    .ea_o         (ea_o)
);

// File: tb/test_modrm_ea_gen.sv
module test_modrm_ea_gen;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic [2:0]        rf_addr;
    logic [ADDR_W-1:0] rf_data;
    logic              done;
    logic [1:0]        mod_f;
    logic [2:0]        reg_f;
    logic [2:0]        rm_f;
    logic              reg_direct;
    logic              sib_err;
    logic [ADDR_W-1:0] ea;

    logic [ADDR_W-1:0] regs [8];

    int n_cmp    = 0;
    int n_bad    = 0;
    int done_cnt = 0;
    int cyc      = 0;
    logic [ADDR_W-1:0] prev_ea = '0;

    always #4 clk = ~clk;

    assign rf_data = regs[rf_addr];

    modrm_ea_gen #(.ADDR_W(ADDR_W)) i_modrm_ea_gen (
        .clk          (clk),
        .rst          (rst),
        .in_valid_i   (in_valid),
        .in_data_i    (in_data),
        .in_ready_o   (in_ready),
        .rf_addr_o    (rf_addr),
        .rf_data_i    (rf_data),
        .done_o       (done),
        .mod_o        (mod_f),
        .reg_o        (reg_f),
        .rm_o         (rm_f),
        .reg_direct_o (reg_direct),
        .sib_err_o    (sib_err),
        .ea_o         (ea)
    );

    always @(negedge clk) if (!rst && done) done_cnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        int w;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        w = 0;
        while (!in_ready && w < 20) begin
            @(negedge clk);
            w++;
        end
        if (!in_ready) chk("R9 ready timeout", 32'(in_ready), 32'd1);
        else @(posedge clk);
    endtask

    task automatic run_vec(input logic [7:0] m, input logic [31:0] db);
        logic [1:0]  md;
        logic [2:0]  r;
        logic        dir;
        logic        esc;
        logic        absl;
        int          nd;
        logic [31:0] disp;
        logic [31:0] exp_ea;
        string       tag;
        int          d0;
        md   = m[7:6];
        r    = m[2:0];
        dir  = (md == 2'b11);
        esc  = !dir && (r == 3'b100);
        absl = (md == 2'b00) && (r == 3'b101);
        if (dir || esc)      nd = 0;
        else if (md == 2'b01) nd = 1;
        else if (md == 2'b10) nd = 4;
        else if (absl)        nd = 4;
        else                  nd = 0;
        if (nd == 1)      disp = {{24{db[7]}}, db[7:0]};
        else if (nd == 4) disp = db;
        else              disp = '0;
        if (esc)             begin exp_ea = '0;            tag = "R7"; end
        else if (dir)        begin exp_ea = '0;            tag = "R6"; end
        else if (absl)       begin exp_ea = db;            tag = "R3"; end
        else if (md == 2'b00) begin exp_ea = regs[r];      tag = "R2"; end
        else if (md == 2'b01) begin exp_ea = regs[r] + disp; tag = "R4"; end
        else                 begin exp_ea = regs[r] + disp; tag = "R5"; end

        d0 = done_cnt;
        send_byte(m);
        for (int i = 0; i < nd; i++) begin
            chk("R8 no early done", 32'(done_cnt - d0), 32'd0);
            send_byte(db[8*i +: 8]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 done not yet", 32'(done), 32'd0);
        chk("R9 ready low before done", 32'(in_ready), 32'd0);
        chk("R9 result held", ea, prev_ea);
        @(negedge clk);
        chk("R8 done strobe", 32'(done), 32'd1);
        chk("R1 mod field", 32'(mod_f), 32'(m[7:6]));
        chk("R1 reg field", 32'(reg_f), 32'(m[5:3]));
        chk("R1 rm field", 32'(rm_f), 32'(m[2:0]));
        chk({tag, " address"}, ea, exp_ea);
        chk("R6 direct flag", 32'(reg_direct), 32'(dir));
        chk("R7 escape flag", 32'(sib_err), 32'(esc));
        if (!dir && !esc && !absl) chk("R2 read index", 32'(rf_addr), 32'(r));
        @(negedge clk);
        chk("R8 done single cycle", 32'(done), 32'd0);
        chk("R9 exactly one completion", 32'(done_cnt - d0), 32'd1);
        prev_ea = exp_ea;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h0000_0061 + 32'(i) * 32'h1111_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset done", 32'(done), 32'd0);
        chk("R10 reset address", ea, 32'd0);
        chk("R10 reset direct", 32'(reg_direct), 32'd0);
        chk("R10 reset escape", 32'(sib_err), 32'd0);
        chk("R10 reset ready", 32'(in_ready), 32'd1);

        // Directed corner cases from the requirements
        run_vec(8'h58, 32'h0000_00FF);
        chk("R4 base 0x61 plus -1", ea, 32'h0000_0060);
        run_vec(8'h98, 32'hFFFF_FFFF);
        chk("R5 base 0x61 plus -1", ea, 32'h0000_0060);
        run_vec(8'h1D, 32'h0000_0060);
        chk("R3 absolute ignores base", ea, 32'h0000_0060);
        run_vec(8'hC3, 32'h0);
        chk("R6 register direct", 32'(reg_direct), 32'd1);

        // Sweep every form byte with register set A
        for (int k = 0; k < 256; k++)
            run_vec(8'(k), {8'(k ^ 8'h5A), 8'(k + 3), 8'(k * 5), 8'(k ^ 8'hC3)});

        // Register set B near the top of the address space, to force wrap
        for (int i = 0; i < 8; i++) regs[i] = 32'hFFFF_FF80 + 32'(i) * 32'h0000_0011;
        for (int k = 0; k < 256; k++)
            run_vec(8'(k), {8'(k), 8'(~k), 8'(k * 3), 8'(k + 8'h80)});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule